// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Preload

This block is one channel of a timer. The counter is outside the block; its value comes in on `cnt_i` and is assumed to run freely. The channel has one data register behind a single read/write port, and a mode input decides what that register means.

In compare mode, software writes a threshold into the register. The register then acts as a staging copy. A second, active register holds the value that is really compared with the counter. With preload disabled, every write reaches the active register at once. With preload enabled, the active register takes the staged value only when an update event arrives. When the counter equals the active value, the channel emits a one-cycle match pulse.

In capture mode, the block synchronizes an external pin and detects its rising edges. On each edge it latches the counter value into the same register, where software can read it. Sticky flags record that a capture happened and whether a second capture overwrote an unread one. The data width is either 32 or 16 bits, while the register port stays 32 bits wide.

Top module: `cc_channel`

## Requirements
- R1: During and right after a synchronous reset, the shared register, the active compare register, `rd_data`, `oc_pulse`, `cap_flag` and `ovr_flag` are all zero.
- R2: In compare mode (`mode_in`=0), a write (`wr_en`) stores `wr_data` in the shared register. A read (`rd_en`) places the register contents on `rd_data` one clock later, and `rd_data` holds that value until the next read.
- R3: In compare mode with `pre_en`=0, a write also loads the active compare register at the same clock edge.
- R4: In compare mode with `pre_en`=1, the active register changes only at an edge where `upd_evt`=1. It takes the value the shared register held before that edge, so a write in the same cycle reaches only the shared register.
- R5: `oc_pulse` is 1 for the single cycle after a cycle in which the block was in compare mode and `cnt_i` equalled the active register. In capture mode it stays 0.
- R6: In capture mode (`mode_in`=1), if `cap_pin` is first sampled high at clock edge k after being sampled low, the shared register holds the `cnt_i` value sampled at edge k+2.
- R7: A capture sets `cap_flag`. A capture while `cap_flag` is already set also sets `ovr_flag`. A read clears both flags. When a read and a capture fall in the same cycle, the result is `cap_flag`=1 and `ovr_flag`=0.
- R8: Writes in capture mode leave the shared register unchanged.
- R9: Changing `mode_in` alters neither the shared register nor the active register. The active register is never loaded in capture mode.
- R10: With W=16, the compare uses a 16-bit counter, bits 31:16 of `wr_data` are ignored, and bits 31:16 of `rd_data` read as zero.
- R11: An `upd_evt` while `pre_en`=0 leaves the active register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_in | input | 1 | 0 = compare mode, 1 = capture mode |
| pre_en | input | 1 | Preload enable for compare mode |
| upd_evt | input | 1 | Update event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (clears the flags) |
| rd_data | output | 32 | Registered read data |
| cnt_i | input | W | External counter value |
| cap_pin | input | 1 | Asynchronous capture input |
| oc_pulse | output | 1 | Registered compare-match pulse |
| cap_flag | output | 1 | Sticky capture flag |
| ovr_flag | output | 1 | Sticky overcapture flag |

## Verification
Two events can land on the same clock edge, and the bench provokes both collisions on purpose.

The first is a software read landing on the edge where a synchronized capture edge latches the counter. The bench raises the pin and then asserts `rd_en` exactly two edges later. It then expects the previous register value on `rd_data`, `cap_flag` set and `ovr_flag` clear.

The second is a write landing on the same edge as an update event while preload is enabled. Here the bench expects the active register to take the old staged value, and confirms this through the cycle in which `oc_pulse` fires.

A behavioural model tracks both 32-bit and 16-bit instances under directed and random stimulus.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
  localparam int CC_BUS_W = 32;
  typedef enum logic {
    CC_COMPARE = 1'b0,
    CC_CAPTURE = 1'b1
  } cc_mode_e;
endpackage

// File: rtl/cc_edge_sync.sv
`timescale 1ns/1ps
module cc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] sh_q;

  // Synchronizer stages followed by one history flop for edge detection.
  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[LEN-2:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cc_compare.sv
`timescale 1ns/1ps
module cc_compare #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmp_mode,
  input  logic         pre_en,
  input  logic         upd,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] stage_val,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] act_q,
  output logic         oc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      oc_q  <= 1'b0;
    end else begin
      if (cmp_mode) begin
        if (!pre_en && wr)      act_q <= wr_val;
        else if (pre_en && upd) act_q <= stage_val;
      end
      oc_q <= cmp_mode && (cnt == act_q);
    end
  end
endmodule

// File: rtl/cc_capture_flags.sv
`timescale 1ns/1ps
module cc_capture_flags (
  input  logic clk,
  input  logic rst,
  input  logic cap,
  input  logic rd,
  output logic cap_q,
  output logic ovr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (cap) begin
      cap_q <= 1'b1;
      ovr_q <= rd ? 1'b0 : (ovr_q | cap_q);
    end else if (rd) begin
      cap_q <= 1'b0;
      ovr_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cc_channel.sv
`timescale 1ns/1ps
module cc_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_in,
  input  logic         pre_en,
  input  logic         upd_evt,
  input  logic         wr_en,
  input  logic [31:0]  wr_data,
  input  logic         rd_en,
  output logic [31:0]  rd_data,
  input  logic [W-1:0] cnt_i,
  input  logic         cap_pin,
  output logic         oc_pulse,
  output logic         cap_flag,
  output logic         ovr_flag
);
  import cc_pkg::*;
  localparam int PAD = CC_BUS_W - W;

  cc_mode_e       mode;
  logic           cmp_mode;
  logic           cap_rise;
  logic           cap_go;
  logic [W-1:0]   reg_q;
  logic [W-1:0]   act_q;
  logic [31:0]    rd_next;

  assign mode     = cc_mode_e'(mode_in);
  assign cmp_mode = (mode == CC_COMPARE);
  assign cap_go   = cap_rise && (mode == CC_CAPTURE);

  generate
    if (PAD > 0) begin : g_pad
      assign rd_next = {{PAD{1'b0}}, reg_q};
    end else begin : g_full
      assign rd_next = reg_q;
    end
  endgenerate

  cc_edge_sync #(.STAGES(2)) sync_i (
    .clk (clk),
    .rst (rst),
    .din (cap_pin),
    .rise(cap_rise)
  );

  // Shared register: staging value in compare mode, capture result otherwise.
  always_ff @(posedge clk) begin
    if (rst)                      reg_q <= '0;
    else if (cap_go)              reg_q <= cnt_i;
    else if (wr_en && cmp_mode)   reg_q <= wr_data[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  cc_compare #(.W(W)) cmp_i (
    .clk      (clk),
    .rst      (rst),
    .cmp_mode (cmp_mode),
    .pre_en   (pre_en),
    .upd      (upd_evt),
    .wr       (wr_en),
    .wr_val   (wr_data[W-1:0]),
    .stage_val(reg_q),
    .cnt      (cnt_i),
    .act_q    (act_q),
    .oc_q     (oc_pulse)
  );

  cc_capture_flags flg_i (
    .clk  (clk),
    .rst  (rst),
    .cap  (cap_go),
    .rd   (rd_en),
    .cap_q(cap_flag),
    .ovr_q(ovr_flag)
  );
endmodule

// File: rtl/cc_channel_chk.sv
`timescale 1ns/1ps
module cc_channel_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_in,
  input logic         pre_en,
  input logic         upd_evt,
  input logic         wr_en,
  input logic [31:0]  wr_data,
  input logic         rd_en,
  input logic [W-1:0] cnt_i,
  input logic         cap_edge,
  input logic [W-1:0] act,
  input logic [W-1:0] reg_val,
  input logic         oc_pulse,
  input logic         cap_flag,
  input logic         ovr_flag
);
  // R3
  direct_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_in && !pre_en && wr_en) |=> (act == $past(wr_data[W-1:0])));

  // R4
  upd_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_in && pre_en && upd_evt) |=> (act == $past(reg_val)));

  // R11
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mode_in && ((!pre_en && wr_en) || (pre_en && upd_evt))) |=> $stable(act));

  // R8
  in_wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_in && !cap_edge) |=> $stable(reg_val));

  // R6
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_in && cap_edge) |=> (reg_val == $past(cnt_i)));

  // R5
  oc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mode_in |=> !oc_pulse);

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !cap_edge) |=> (!cap_flag && !ovr_flag));

  // R7
  ovr_implies_cap_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_flag |-> cap_flag);
endmodule

bind cc_channel cc_channel_chk #(.W(W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .mode_in (mode_in),
  .pre_en  (pre_en),
  .upd_evt (upd_evt),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .cnt_i   (cnt_i),
  .cap_edge(cap_rise),
  .act     (act_q),
  .reg_val (reg_q),
  .oc_pulse(oc_pulse),
  .cap_flag(cap_flag),
  .ovr_flag(ovr_flag)
);

// File: tb/cc_channel_tb_top.sv
`timescale 1ns/1ps
module cc_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        md = 1'b0, pre = 1'b0, upd = 1'b0, wr = 1'b0, rd = 1'b0, pin = 1'b0;
  logic [31:0] wdat = '0;
  logic [31:0] cnt = '0;
  logic        cnt_run = 1'b0;
  logic [31:0] rd32, rd16;
  logic        oc32, oc16, cf32, cf16, of32, of16;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  cc_channel #(.W(32)) dut_i (
    .clk(clk), .rst(rst), .mode_in(md), .pre_en(pre), .upd_evt(upd),
    .wr_en(wr), .wr_data(wdat), .rd_en(rd), .rd_data(rd32), .cnt_i(cnt),
    .cap_pin(pin), .oc_pulse(oc32), .cap_flag(cf32), .ovr_flag(of32));

  cc_channel #(.W(16)) dut16_i (
    .clk(clk), .rst(rst), .mode_in(md), .pre_en(pre), .upd_evt(upd),
    .wr_en(wr), .wr_data(wdat), .rd_en(rd), .rd_data(rd16), .cnt_i(cnt[15:0]),
    .cap_pin(pin), .oc_pulse(oc16), .cap_flag(cf16), .ovr_flag(of16));

  // Behavioural reference, index 0 = 32-bit build, index 1 = 16-bit build.
  logic [31:0] m_reg [2], m_act [2], m_rd [2];
  logic        m_oc [2], m_cf [2], m_of [2];
  logic [2:0]  hist = '0;
  logic        m_valid = 1'b0;

  function automatic logic [31:0] msk(int i);
    return (i == 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  always @(posedge clk) begin
    logic rise;
    rise = hist[1] & ~hist[2];
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_reg[i] = '0; m_act[i] = '0; m_rd[i] = '0;
        m_oc[i] = 0; m_cf[i] = 0; m_of[i] = 0;
      end
      hist = '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic cap;
        logic [31:0] c;
        c = cnt & msk(i);
        cap = rise && md;
        if (rd) m_rd[i] = m_reg[i];
        m_oc[i] = !md && (c == m_act[i]);
        if (!md) begin
          if (!pre && wr)      m_act[i] = wdat & msk(i);
          else if (pre && upd) m_act[i] = m_reg[i];
        end
        if (cap)            m_reg[i] = c;
        else if (wr && !md) m_reg[i] = wdat & msk(i);
        if (cap) begin
          m_of[i] = rd ? 1'b0 : (m_of[i] | m_cf[i]);
          m_cf[i] = 1'b1;
        end else if (rd) begin
          m_cf[i] = 0; m_of[i] = 0;
        end
      end
      hist = {hist[1:0], pin};
    end
    m_valid = 1'b1;
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk("R2 rd_data w32", rd32, m_rd[0]);
      chk("R10 rd_data w16", rd16, m_rd[1]);
      chk("R5 oc_pulse w32", {31'd0, oc32}, {31'd0, m_oc[0]});
      chk("R5 oc_pulse w16", {31'd0, oc16}, {31'd0, m_oc[1]});
      chk("R7 cap_flag w32", {31'd0, cf32}, {31'd0, m_cf[0]});
      chk("R7 cap_flag w16", {31'd0, cf16}, {31'd0, m_cf[1]});
      chk("R7 ovr_flag w32", {31'd0, of32}, {31'd0, m_of[0]});
      chk("R7 ovr_flag w16", {31'd0, of16}, {31'd0, m_of[1]});
    end
  end

  task automatic step();
    @(negedge clk); #1;
    if (cnt_run) cnt = cnt + 1;
  endtask

  task automatic do_wr(logic [31:0] v);
    wr = 1; wdat = v; step(); wr = 0;
  endtask

  task automatic do_rd();
    rd = 1; step(); rd = 0;
  endtask

  task automatic pin_edge_wait();
    pin = 0; repeat (3) step();
    pin = 1; repeat (4) step();
  endtask

  task automatic wrap_up();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    wrap_up();
  end

  initial begin
    logic [31:0] c0;
    repeat (3) step();
    // R1 reset state
    chk("R1 rd_data", rd32, 32'h0);
    chk("R1 flags", {29'd0, oc32, cf32, of32}, 32'h0);
    rst = 0;

    // R2/R3/R10: direct load with preload off
    cnt = 32'h5;
    do_wr(32'hABCD_0005);
    do_rd();
    chk("R2 readback w32", rd32, 32'hABCD_0005);
    chk("R10 upper half zero w16", rd16, 32'h0000_0005);
    chk("R3 immediate active w16 match", {31'd0, oc16}, 32'd1);
    chk("R3 no match w32", {31'd0, oc32}, 32'd0);
    cnt = 32'hABCD_0005; step();
    chk("R5 match pulse w32", {31'd0, oc32}, 32'd1);

    // R4: deferred load, write colliding with update
    pre = 1;
    do_wr(32'h100);
    cnt = 32'h100; step();
    chk("R4 active held", {31'd0, oc32}, 32'd0);
    upd = 1; wr = 1; wdat = 32'h200; step(); upd = 0; wr = 0;
    step();
    chk("R4 update takes old staged value", {31'd0, oc32}, 32'd1);
    upd = 1; step(); upd = 0;
    cnt = 32'h200; step();
    chk("R4 second update", {31'd0, oc32}, 32'd1);
    do_wr(32'h300);
    pre = 0; upd = 1; step(); upd = 0; step();
    chk("R11 update ignored without preload", {31'd0, oc32}, 32'd1);
    do_rd();
    chk("R2 staged value readback", rd32, 32'h300);

    // R5/R8/R9: capture mode
    md = 1; step(); step();
    chk("R5 no pulse in capture mode", {31'd0, oc32}, 32'd0);
    do_rd();
    chk("R9 register kept across mode change", rd32, 32'h300);
    do_wr(32'hDEAD);
    do_rd();
    chk("R8 write ignored in capture mode", rd32, 32'h300);

    // R6/R7: capture timing and flags
    cnt = 32'h0001_1000; cnt_run = 1;
    pin = 0; repeat (3) step();
    c0 = cnt;
    pin = 1; repeat (3) step();
    chk("R7 capture flag set", {30'd0, cf32, of32}, 32'd2);
    step();
    do_rd();
    chk("R6 captured count w32", rd32, c0 + 2);
    chk("R6 captured count w16", rd16, (c0 + 2) & 32'hFFFF);
    chk("R7 read clears flags", {30'd0, cf32, of32}, 32'd0);
    pin_edge_wait();
    pin_edge_wait();
    chk("R7 overcapture", {30'd0, cf32, of32}, 32'd3);
    do_rd();
    pin = 0; repeat (3) step();
    pin = 1; step(); step();
    rd = 1; step(); rd = 0;
    chk("R7 read and capture collide", {30'd0, cf32, of32}, 32'd2);
    pin = 0; step();

    // R9: active register survived capture mode
    md = 0; cnt_run = 0; cnt = 32'h200; step(); step();
    chk("R9 active kept", {31'd0, oc32}, 32'd1);
    do_wr(32'hFFFF_1234);
    do_rd();
    chk("R10 write upper half ignored w16", rd16, 32'h0000_1234);
    chk("R2 full width w32", rd32, 32'hFFFF_1234);

    // Random traffic against the model
    cnt_run = 1;
    for (int n = 0; n < 600; n++) begin
      wr = ($urandom % 4) == 0; wdat = {$urandom} & 32'h0000_003F;
      rd = ($urandom % 5) == 0; upd = ($urandom % 6) == 0;
      pin = ($urandom % 3) == 0;
      if ((n % 50) == 0) begin md = $urandom; pre = $urandom; end
      if ((n % 7) == 0) cnt = {$urandom} & 32'h3F;
      step();
    end
    wr = 0; rd = 0; upd = 0; pin = 0;
    step(); step();
    wrap_up();
  end
endmodule